// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two bidirectional 8-bit buses, called A and B. Each bus has its own capture register. Each register loads on its own strobe, and that strobe is sampled on one shared system clock. A register always samples the value that is resolved on its own bus, even when this block is the one driving that bus. Each output direction has its own enable and its own select. The select picks either the live value from the opposite bus or the value held in that bus's register. This gives real-time pass-through, stored playback, copying one value into both registers, and exchanging the two stored values.

The block has no tristate pins. Each bus is presented as a resolved input vector, a driven output vector and an output-enable flag, and a wrapper outside the block resolves the wire. If both directions are enabled and either select is live, the two pass paths would form a loop through the buses. The block detects this case, drives both buses from their registers instead, and raises a conflict flag.

Top module: `bus_xcvr_reg`

## Requirements
- R1: While rst_ni is low, both capture registers clear to zero asynchronously.
- R2: When cap_a_i is high at a rising clock edge, the A register loads a_bus_i, whatever the enables are. Otherwise it holds its value.
- R3: When cap_b_i is high at a rising clock edge, the B register loads b_bus_i, whatever the enables are. Otherwise it holds its value.
- R4: b_oe_o is 1 exactly when en_ab_i is 1 (active-high enable for driving B).
- R5: a_oe_o is 1 exactly when en_ba_ni is 0 (active-low enable for driving A).
- R6: With en_ab_i=0 and en_ba_ni=1, neither bus is driven, and both registers still load on their strobes, including on the same edge.
- R7: When B is driven and no conflict exists, sel_ab_i=0 puts a_bus_i on b_out_o combinationally, and sel_ab_i=1 puts the A register on b_out_o.
- R8: When A is driven and no conflict exists, sel_ba_i=0 puts b_bus_i on a_out_o combinationally, and sel_ba_i=1 puts the B register on a_out_o.
- R9: If B is driven from live A and both strobes are high on one edge, both registers hold the A bus value. Driving A from live B leaves the B bus value in both registers.
- R10: With both directions enabled and both selects at 1, b_out_o shows the A register and a_out_o shows the B register at the same time. Strobing both registers then swaps their contents.
- R11: With both directions enabled and either select at 0, conflict_o is 1 and both outputs come from their registers. In every other case conflict_o is 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_bus_i | input | 8 | Resolved value on bus A |
| b_bus_i | input | 8 | Resolved value on bus B |
| cap_a_i | input | 1 | A register load strobe |
| cap_b_i | input | 1 | B register load strobe |
| en_ab_i | input | 1 | Drive bus B, active high |
| en_ba_ni | input | 1 | Drive bus A, active low |
| sel_ab_i | input | 1 | B output source: 0 live A, 1 A register |
| sel_ba_i | input | 1 | A output source: 0 live B, 1 B register |
| a_out_o | output | 8 | Value driven onto bus A |
| a_oe_o | output | 1 | Bus A output enable |
| b_out_o | output | 8 | Value driven onto bus B |
| b_oe_o | output | 1 | Bus B output enable |
| conflict_o | output | 1 | Both directions enabled with a live select |

## Verification
The registers can only be seen through the stored-select paths, so a wrong captured or held value appears on the opposite bus's output in the first cycle that path is selected after the faulty edge. The bench reads both registers back after every copy, swap and isolated-capture case. A wrong select or conflict decision corrupts the driven bus in the same cycle. Because each register samples its own resolved bus, that corruption also spreads into the registers on the next strobe.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  parameter int XCVR_W = 8;

  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_TO_B = 2'b01,
    DIR_TO_A = 2'b10,
    DIR_BOTH = 2'b11
  } dir_e;
endpackage

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> q_o == $past(d_i));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(q_o));
endmodule

// File: rtl/xcvr_out_sel.sv
module xcvr_out_sel #(
  parameter int W = 8
) (
  input  logic         use_reg_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] held_i,
  output logic [W-1:0] y_o
);
  always_comb y_o = use_reg_i ? held_i : live_i;
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import xcvr_pkg::*;
#(
  parameter int W = XCVR_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_bus_i,
  input  logic [W-1:0] b_bus_i,
  input  logic         cap_a_i,
  input  logic         cap_b_i,
  input  logic         en_ab_i,
  input  logic         en_ba_ni,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  output logic [W-1:0] a_out_o,
  output logic         a_oe_o,
  output logic [W-1:0] b_out_o,
  output logic         b_oe_o,
  output logic         conflict_o
);
  dir_e dir;
  logic [W-1:0] q_a, q_b;
  logic loop_risk;

  assign dir       = dir_e'({~en_ba_ni, en_ab_i});
  assign loop_risk = (dir == DIR_BOTH) && !(sel_ab_i && sel_ba_i);
  assign conflict_o = loop_risk;
  assign b_oe_o    = (dir == DIR_TO_B) || (dir == DIR_BOTH);
  assign a_oe_o    = (dir == DIR_TO_A) || (dir == DIR_BOTH);

  xcvr_cap_reg #(.W(W)) u_reg_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap_a_i), .d_i(a_bus_i), .q_o(q_a));
  xcvr_cap_reg #(.W(W)) u_reg_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(cap_b_i), .d_i(b_bus_i), .q_o(q_b));

  // conflict forces stored data to break the bus loop
  xcvr_out_sel #(.W(W)) u_sel_b (
    .use_reg_i(sel_ab_i | loop_risk), .live_i(a_bus_i), .held_i(q_a), .y_o(b_out_o));
  xcvr_out_sel #(.W(W)) u_sel_a (
    .use_reg_i(sel_ba_i | loop_risk), .live_i(b_bus_i), .held_i(q_b), .y_o(a_out_o));

  p_live_b_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_oe_o && !sel_ab_i && !conflict_o) |-> b_out_o == a_bus_i);
  p_live_a_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o && !sel_ba_i && !conflict_o) |-> a_out_o == b_bus_i);
  p_swap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o && b_oe_o) |-> (b_out_o == q_a && a_out_o == q_b));
  p_conflict_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |-> (a_oe_o && b_oe_o));
  p_isolate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ab_i && en_ba_ni) |-> !(a_oe_o || b_oe_o || conflict_o));
endmodule

// File: tb/sim_bus_xcvr_reg.sv
`timescale 1ns/1ps
module sim_bus_xcvr_reg;
  localparam int W = 8;
  logic clk = 0, rst_ni = 0;
  logic [W-1:0] ext_a = '0, ext_b = '0, bus_a, bus_b;
  logic cap_a = 0, cap_b = 0, en_ab = 0, en_ba_n = 1, sel_ab = 0, sel_ba = 0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe, conflict;
  logic [W-1:0] ma = '0, mb = '0;
  int n_run = 0, n_fail = 0;
  logic done = 0;

  always #2.5 clk = ~clk;

  always @* bus_a = a_oe ? a_out : ext_a;
  always @* bus_b = b_oe ? b_out : ext_b;

  bus_xcvr_reg #(.W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .a_bus_i(bus_a), .b_bus_i(bus_b),
    .cap_a_i(cap_a), .cap_b_i(cap_b), .en_ab_i(en_ab), .en_ba_ni(en_ba_n),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .a_out_o(a_out), .a_oe_o(a_oe),
    .b_out_o(b_out), .b_oe_o(b_oe), .conflict_o(conflict));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected resolved buses from the requirements
  function automatic logic [2*W:0] model(input logic eab, input logic ebn,
      input logic sab, input logic sba, input logic [W-1:0] xa, input logic [W-1:0] xb,
      input logic [W-1:0] ra, input logic [W-1:0] rb);
    logic [W-1:0] ea, eb;
    logic cf;
    cf = eab && !ebn && !(sab && sba);
    ea = xa; eb = xb;
    if (eab && !ebn) begin eb = ra; ea = rb; end
    else if (eab) eb = sab ? ra : xa;
    else if (!ebn) ea = sba ? rb : xb;
    return {cf, ea, eb};
  endfunction

  task automatic cyc(input logic eab, input logic ebn, input logic sab, input logic sba,
      input logic ca, input logic cb, input logic [W-1:0] xa, input logic [W-1:0] xb,
      input string tag);
    logic [2*W:0] e;
    @(negedge clk);
    en_ab = eab; en_ba_n = ebn; sel_ab = sab; sel_ba = sba;
    cap_a = ca; cap_b = cb; ext_a = xa; ext_b = xb;
    #1;
    e = model(eab, ebn, sab, sba, xa, xb, ma, mb);
    chk({tag, " R4 b_oe"}, W'(b_oe), W'(eab));
    chk({tag, " R5 a_oe"}, W'(a_oe), W'(!ebn));
    chk({tag, " R11 conflict"}, W'(conflict), W'(e[2*W]));
    if (eab)  chk({tag, " R7 b_out"}, b_out, e[W-1:0]);
    if (!ebn) chk({tag, " R8 a_out"}, a_out, e[2*W-1:W]);
    @(posedge clk);
    if (ca) ma = e[2*W-1:W];
    if (cb) mb = e[W-1:0];
  endtask

  task automatic peek(input string req);
    cyc(1, 1, 1, 0, 0, 0, 8'h00, 8'h00, req);
    chk({req, " regA"}, b_out, ma);
    cyc(0, 0, 0, 1, 0, 0, 8'h00, 8'h00, req);
    chk({req, " regB"}, a_out, mb);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    #12;
    chk("R1 reset b_oe", W'(b_oe), '0);
    rst_ni = 1;
    peek("R1 reset");
    // R6 isolation with simultaneous capture
    cyc(0, 1, 1, 1, 1, 1, 8'h3c, 8'hc3, "R6 iso");
    chk("R6 no drive", W'({a_oe, b_oe}), '0);
    peek("R6 iso cap");
    // R2 capture while driving A from B register
    cyc(0, 0, 0, 1, 1, 0, 8'h11, 8'h5a, "R2 drive");
    peek("R2 cap own bus");
    // R9 copy A into both
    cyc(1, 1, 0, 0, 1, 1, 8'ha5, 8'hff, "R9 copyA");
    peek("R9 copyA");
    // R9 copy B into both
    cyc(0, 0, 0, 0, 1, 1, 8'h00, 8'h6e, "R9 copyB");
    peek("R9 copyB");
    // R10 swap
    cyc(0, 1, 0, 0, 1, 0, 8'h12, 8'h00, "R10 ldA");
    cyc(0, 1, 0, 0, 0, 1, 8'h00, 8'h34, "R10 ldB");
    cyc(1, 0, 1, 1, 1, 1, 8'h00, 8'h00, "R10 swap");
    peek("R10 swapped");
    // R11 conflict cases
    cyc(1, 0, 0, 1, 0, 0, 8'h77, 8'h88, "R11 c1");
    cyc(1, 0, 1, 0, 0, 0, 8'h77, 8'h88, "R11 c2");
    cyc(1, 0, 0, 0, 1, 1, 8'h77, 8'h88, "R11 c3");
    peek("R11 regs");
    // R3 hold / random mix
    for (int i = 0; i < 400; i++) begin
      logic [9:0] r;
      r = 10'($urandom);
      cyc(r[0], r[1], r[2], r[3], r[4], r[5], 8'($urandom), 8'($urandom), "R3 rnd");
      if (i % 50 == 0) peek("R2 R3 rnd");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule